// File: doc/BRIEF.md
# Windowed Buffer Access Port

This block puts a byte-wide single-port RAM buffer behind a small register bus. The host never addresses the RAM directly. It reads and writes a single data window register. A read pointer selects the location a window read fetches, and a separate write pointer selects the location a window write stores to. An auto-advance control bit, set out of reset, moves whichever pointer an access used on by one location afterwards. Long sequential transfers therefore need no pointer updates between bytes.

The read pointer runs inside a receive ring that the host programs with a start bound and an end bound. A sequential read taken at the end bound returns the read pointer to the start bound. The write pointer ignores both bounds and only wraps at the top of the address space. The buffer works as plain storage whether or not anything else uses it.

The block also models a side effect of the host core. A single-cycle instruction that writes the window first performs a dummy read, so that write advances the read pointer as well. The host marks each window write as single-cycle or two-cycle on a bus input. An operation that reads and writes the window at once is not supported.

Top module: `bufwin_top`

## Requirements
- R1: A window write (register address 9) stores `bus_wdata` at the write pointer. A window read returns the byte at the read pointer on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request. Any read request raises `bus_rvalid` exactly one cycle later.
- R2: Bit 0 of the control register (address 8) enables auto-advance. When it is set, the pointer used by a window access moves on by one afterwards. When it is clear, a window access changes neither pointer.
- R3: After reset, auto-advance is 1, both pointers and the ring start are 0, the ring end is 0x1FFF, and `bus_rvalid` is 0.
- R4: A window read with auto-advance on, taken when the read pointer equals the ring end, loads the read pointer with the ring start.
- R5: A window write never wraps at the ring end. The write pointer increments past it.
- R6: A window write with `bus_single`=1 and auto-advance on also moves the read pointer on, using the ring rule of R4. A window write with `bus_single`=0 leaves the read pointer unchanged.
- R7: Pointers are 13 bits wide and increment modulo 8192, so 0x1FFF advances to 0, except where R4 applies.
- R8: The register map is as follows: 0/1 read pointer low/high, 2/3 write pointer low/high, 4/5 ring start low/high, 6/7 ring end low/high. A low half holds bits 7:0. A high half holds bits 12:8 in data bits 4:0 and reads back with zeros above. A value written to a pointer is used by the next window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_single | input | 1 | Window write is a single-cycle instruction |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |

## Verification
A single-cycle window write drives two pointer updates in the same cycle. The write pointer advances, and the read pointer advances through the dummy read, which can itself trigger the ring wrap. The bench provokes this first with the read pointer in the middle of the buffer and then with it parked on the ring end. It judges the result by reading the read pointer back over the bus, and by the byte that the next window read returns. It also pairs a write that runs past the ring end with reads that wrap at that end, so the bound is seen to affect only the read path.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - 8;
    localparam int SEL_W  = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [SEL_W-1:0] {
        REG_RPTR_LO = 4'd0,
        REG_RPTR_HI = 4'd1,
        REG_WPTR_LO = 4'd2,
        REG_WPTR_HI = 4'd3,
        REG_RST_LO  = 4'd4,
        REG_RST_HI  = 4'd5,
        REG_REND_LO = 4'd6,
        REG_REND_HI = 4'd7,
        REG_CTRL    = 4'd8,
        REG_WINDOW  = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic wr_win;
        logic rd_win;
        logic dummy_rd;
        logic wr_reg;
        logic rd_any;
    } acc_s;

    localparam addr_t RING_END_RST = '1;

    // next read position: ring end folds back to ring start
    function automatic addr_t ring_next(addr_t p, addr_t st, addr_t en);
        return (p == en) ? st : addr_t'(p + 1'b1);
    endfunction

    function automatic byte_t hi_half(addr_t p);
        return byte_t'(p[ADDR_W-1:8]);
    endfunction
endpackage

// File: rtl/bufwin_decode.sv
module bufwin_decode
    import bufwin_pkg::*;
(
    input  logic             sel,
    input  logic             we,
    input  logic [SEL_W-1:0] addr,
    input  logic             single,
    output acc_s             acc
);
    logic is_win;

    always_comb begin
        is_win       = (addr == REG_WINDOW);
        acc.wr_win   = sel && we && is_win;
        acc.rd_win   = sel && !we && is_win;
        acc.dummy_rd = sel && we && is_win && single;
        acc.wr_reg   = sel && we && !is_win;
        acc.rd_any   = sel && !we;
    end
endmodule

// File: rtl/bufwin_regs.sv
module bufwin_regs
    import bufwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_s             acc,
    input  logic [SEL_W-1:0] addr,
    input  byte_t            wdata,
    output addr_t            rptr,
    output addr_t            wptr,
    output addr_t            ring_st,
    output addr_t            ring_end,
    output logic             autoinc,
    output byte_t            reg_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rptr     <= '0;
            wptr     <= '0;
            ring_st  <= '0;
            ring_end <= RING_END_RST;
            autoinc  <= 1'b1;
        end else begin
            if (acc.wr_reg) begin
                case (addr)
                    REG_RPTR_LO: rptr[7:0]            <= wdata;
                    REG_RPTR_HI: rptr[ADDR_W-1:8]     <= wdata[HI_W-1:0];
                    REG_WPTR_LO: wptr[7:0]            <= wdata;
                    REG_WPTR_HI: wptr[ADDR_W-1:8]     <= wdata[HI_W-1:0];
                    REG_RST_LO:  ring_st[7:0]         <= wdata;
                    REG_RST_HI:  ring_st[ADDR_W-1:8]  <= wdata[HI_W-1:0];
                    REG_REND_LO: ring_end[7:0]        <= wdata;
                    REG_REND_HI: ring_end[ADDR_W-1:8] <= wdata[HI_W-1:0];
                    REG_CTRL:    autoinc              <= wdata[0];
                    default: ;
                endcase
            end
            if (acc.wr_win && autoinc)
                wptr <= addr_t'(wptr + 1'b1);
            if ((acc.rd_win || acc.dummy_rd) && autoinc)
                rptr <= ring_next(rptr, ring_st, ring_end);
        end
    end

    always_comb begin
        case (addr)
            REG_RPTR_LO: reg_rdata = rptr[7:0];
            REG_RPTR_HI: reg_rdata = hi_half(rptr);
            REG_WPTR_LO: reg_rdata = wptr[7:0];
            REG_WPTR_HI: reg_rdata = hi_half(wptr);
            REG_RST_LO:  reg_rdata = ring_st[7:0];
            REG_RST_HI:  reg_rdata = hi_half(ring_st);
            REG_REND_LO: reg_rdata = ring_end[7:0];
            REG_REND_HI: reg_rdata = hi_half(ring_end);
            REG_CTRL:    reg_rdata = byte_t'(autoinc);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bufwin_ram.sv
module bufwin_ram #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wd;
            else    rd        <= mem[addr];
        end
    end
endmodule

// File: rtl/bufwin_top.sv
module bufwin_top
    import bufwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_single,
    output logic [7:0]       bus_rdata,
    output logic             bus_rvalid
);
    acc_s  acc;
    addr_t rptr, wptr, ring_st, ring_end;
    logic  autoinc;
    byte_t reg_rdata, ram_q, reg_q;
    logic  win_q;
    addr_t ram_addr;

    bufwin_decode dec_i (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr),
        .single(bus_single), .acc(acc)
    );

    bufwin_regs regs_i (
        .clk(clk), .rst(rst), .acc(acc), .addr(bus_addr), .wdata(bus_wdata),
        .rptr(rptr), .wptr(wptr), .ring_st(ring_st), .ring_end(ring_end),
        .autoinc(autoinc), .reg_rdata(reg_rdata)
    );

    // writes use the write pointer, everything else the read pointer
    assign ram_addr = acc.wr_win ? wptr : rptr;

    bufwin_ram #(.AW(ADDR_W), .DW(DATA_W)) ram_i (
        .clk(clk), .en(acc.wr_win || acc.rd_win), .we(acc.wr_win),
        .addr(ram_addr), .wd(bus_wdata), .rd(ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            win_q      <= 1'b0;
            reg_q      <= '0;
        end else begin
            bus_rvalid <= acc.rd_any;
            win_q      <= acc.rd_win;
            if (acc.rd_any) reg_q <= reg_rdata;
        end
    end

    assign bus_rdata = win_q ? ram_q : reg_q;
endmodule

// File: rtl/bufwin_chk.sv
module bufwin_chk
    import bufwin_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [SEL_W-1:0] bus_addr,
    input logic             bus_single,
    input logic             bus_rvalid,
    input addr_t            rptr,
    input addr_t            wptr,
    input addr_t            ring_st,
    input addr_t            ring_end,
    input logic             autoinc
);
    logic win_wr, win_rd;
    assign win_wr = bus_sel && bus_we && (bus_addr == REG_WINDOW);
    assign win_rd = bus_sel && !bus_we && (bus_addr == REG_WINDOW);

    // R1
    a_r1_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we) |=> bus_rvalid);
    // R1
    a_r1_rvalid_only_reads: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_sel && !bus_we));
    // R2, R5, R7
    a_r2_wptr_step: assert property (@(posedge clk) disable iff (rst)
        (win_wr && autoinc) |=> (wptr == addr_t'($past(wptr) + 1'b1)));
    // R2
    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        ((win_wr || win_rd) && !autoinc) |=> ($stable(wptr) && $stable(rptr)));
    // R3
    a_r3_autoinc_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (autoinc && rptr == '0 && wptr == '0));
    // R4
    a_r4_ring_wrap: assert property (@(posedge clk) disable iff (rst)
        (win_rd && autoinc && rptr == ring_end) |=> (rptr == $past(ring_st)));
    // R6
    a_r6_two_cycle_keep: assert property (@(posedge clk) disable iff (rst)
        (win_wr && !bus_single) |=> $stable(rptr));
    // R6
    a_r6_single_advance: assert property (@(posedge clk) disable iff (rst)
        (win_wr && bus_single && autoinc && rptr != ring_end)
        |=> (rptr == addr_t'($past(rptr) + 1'b1)));
endmodule

bind bufwin_top bufwin_chk chk_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_single(bus_single), .bus_rvalid(bus_rvalid),
    .rptr(rptr), .wptr(wptr), .ring_st(ring_st), .ring_end(ring_end),
    .autoinc(autoinc)
);

// File: tb/bufwin_top_tb_top.sv
module bufwin_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_we = 1'b0, bus_single = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;

    int total = 0, bad = 0, cycles = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    bufwin_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_single(bus_single),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    // vector: [22] we, [21] single, [20:17] addr, [16:9] wdata, [8] check, [7:0] expected
    localparam int NV = 20;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd9, 8'h11, 1'b0, 8'h00},  // mem[0]
        {1'b1, 1'b0, 4'd9, 8'h22, 1'b0, 8'h00},  // mem[1]
        {1'b1, 1'b1, 4'd9, 8'h33, 1'b0, 8'h00},  // mem[2], rptr->1
        {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h22},
        {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h33},
        {1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 8'h03},
        {1'b0, 1'b0, 4'd2, 8'h00, 1'b1, 8'h03},
        {1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 8'h00},
        {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h11},
        {1'b1, 1'b0, 4'd8, 8'h00, 1'b0, 8'h00},  // auto-advance off
        {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h22},
        {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h22},
        {1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 8'h01},
        {1'b1, 1'b1, 4'd9, 8'h44, 1'b0, 8'h00},
        {1'b1, 1'b0, 4'd9, 8'h55, 1'b0, 8'h00},
        {1'b0, 1'b0, 4'd2, 8'h00, 1'b1, 8'h03},
        {1'b1, 1'b0, 4'd8, 8'h01, 1'b0, 8'h00},
        {1'b1, 1'b0, 4'd0, 8'h03, 1'b0, 8'h00},
        {1'b0, 1'b0, 4'd9, 8'h00, 1'b1, 8'h55},
        {1'b0, 1'b0, 4'd8, 8'h00, 1'b1, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic single, input logic [3:0] a,
                          input logic [7:0] d, output logic [7:0] rd, output logic rv);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_single = single; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata; rv = bus_rvalid;
        bus_sel = 1'b0; bus_we = 1'b0; bus_single = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic single);
        logic [7:0] rd; logic rv;
        bus_op(1'b1, single, a, d, rd, rv);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] rd; logic rv;
        bus_op(1'b0, 1'b0, a, 8'h00, rd, rv);
        check(req, rd, exp);
        check("R1 rvalid", {7'b0, rv}, 8'h01);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R3 reset state
        check("R3 rvalid", {7'b0, bus_rvalid}, 8'h00);
        rd_chk("R3 ctrl", 4'd8, 8'h01);
        rd_chk("R3 rptr", 4'd0, 8'h00);
        rd_chk("R3 wptr", 4'd2, 8'h00);
        rd_chk("R3 ring start", 4'd4, 8'h00);
        rd_chk("R3 ring end lo", 4'd6, 8'hFF);
        rd_chk("R3 ring end hi", 4'd7, 8'h1F);

        // table: R1 R2 R6 R8
        for (int i = 0; i < NV; i++) begin
            logic [7:0] rd; logic rv;
            bus_op(VEC[i][22], VEC[i][21], VEC[i][20:17], VEC[i][16:9], rd, rv);
            if (VEC[i][8]) begin
                check($sformatf("R1/R2/R6/R8 vec%0d", i), rd, VEC[i][7:0]);
                check("R1 rvalid", {7'b0, rv}, 8'h01);
            end
        end

        // ring: start 0x010, end 0x012
        do_reset();
        wr(4'd4, 8'h10, 1'b0); wr(4'd6, 8'h12, 1'b0); wr(4'd7, 8'h00, 1'b0);
        wr(4'd2, 8'h10, 1'b0);
        wr(4'd9, 8'hA0, 1'b0); wr(4'd9, 8'hA1, 1'b0);
        wr(4'd9, 8'hA2, 1'b0); wr(4'd9, 8'hA3, 1'b0);
        rd_chk("R5 write passes ring end", 4'd2, 8'h14);
        wr(4'd0, 8'h10, 1'b0);
        rd_chk("R4 read a", 4'd9, 8'hA0);
        rd_chk("R4 read b", 4'd9, 8'hA1);
        rd_chk("R4 read end", 4'd9, 8'hA2);
        rd_chk("R4 wrapped read", 4'd9, 8'hA0);
        // single-cycle write while read pointer sits on ring end
        wr(4'd0, 8'h12, 1'b0);
        wr(4'd9, 8'hC5, 1'b1);
        rd_chk("R6 dummy read wraps", 4'd0, 8'h10);
        rd_chk("R6 wptr advanced", 4'd2, 8'h15);
        rd_chk("R5 mem beyond end", 4'd9, 8'hA0);

        // R7 top-of-space wrap
        wr(4'd2, 8'hFF, 1'b0); wr(4'd3, 8'h1F, 1'b0);
        rd_chk("R8 hi readback", 4'd3, 8'h1F);
        wr(4'd9, 8'hB7, 1'b0);
        rd_chk("R7 wptr lo", 4'd2, 8'h00);
        rd_chk("R7 wptr hi", 4'd3, 8'h00);
        wr(4'd0, 8'hFF, 1'b0); wr(4'd1, 8'hFF, 1'b0);
        rd_chk("R8 hi masked", 4'd1, 8'h1F);
        rd_chk("R7 top byte", 4'd9, 8'hB7);
        rd_chk("R7 rptr lo", 4'd0, 8'h00);
        rd_chk("R7 rptr hi", 4'd1, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule